// File: doc/BRIEF.md
# ECC Error Status and Interrupt Unit

This unit sits beside a memory wrapper that checks and corrects its words with an error-correcting code. The wrapper reports each corrected single-bit error and each uncorrectable double-bit error as a one-cycle pulse with the failing address. The unit turns these pulses into sticky status flags. It can also record the failing addresses and raise either a maskable interrupt or a non-maskable interrupt (NMI). It also holds the code enable bit for the memory, and that bit can only be turned off after a two-byte key has been written.

Software reaches the unit through a simple register port: a 3-bit register index, a write strobe with 8 bits of write data, and read data that is registered one cycle after the index is presented. The error arithmetic and the memory array are outside this block.

Top module: `ecc_err_ctrl`

## Requirements
- R1: On synchronous reset, all flags, enables, the NMI select and both address registers are 0, `irq`, `nmi` and `reg_rdata` are 0, and the code enable bit takes the value of `ecc_en_cfg`.
- R2: While the code enable bit is 1, a `sec_pulse` sets status bit 0 and a `ded_pulse` sets status bit 1 at the next clock edge. Status is at index 2.
- R3: While a status flag is 1, further pulses of that kind change neither the flag nor its address register.
- R4: A flag that goes from 0 to 1 stores its pulse's address in its address register (single at index 4, double at index 5) only if control bit 1 (address latch) is 1 in that cycle. Otherwise the register keeps its old value.
- R5: Writing 1 to bit 0 or bit 1 of the clear register (index 3) clears the single or double flag. Reading index 3 returns the flags. A clear that meets a new pulse of the same kind while the flag is set leaves the flag at 0.
- R6: `irq` is 1 one cycle after (single flag and single enable) or (double flag and double enable and NMI select = 0). The interrupt enable register is at index 1: bit 0 is the single enable, bit 1 the double enable and bit 2 the NMI select.
- R7: `nmi` is 1 one cycle after (double flag and NMI select). Writing 1 sets the NMI select, and writing 0 leaves it unchanged. While the NMI select is 1, a double error never raises `irq`.
- R8: The code enable bit is control bit 0 (index 0). Writing 1 sets it at any time. Writing 0 clears it only when key 0xAE and then key 0x75 were written to the key register (index 6) before that control write.
- R9: A key write that breaks the 0xAE-then-0x75 order locks again. A write of 0xAE always restarts at the second step. The first control write after an unlock uses the unlock up.
- R10: While the code enable bit is 0, both error pulses are ignored.
- R11: Read data at index N appears one cycle after `reg_sel` = N. Indices 6 and 7 read as 0, and index 0 reads {latch, enable} in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en_cfg | input | 1 | Reset value of the code enable bit |
| reg_sel | input | 3 | Register index |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| sec_pulse | input | 1 | Corrected single error event |
| sec_addr | input | ADDR_W | Address of single error |
| ded_pulse | input | 1 | Double error event |
| ded_addr | input | ADDR_W | Address of double error |
| irq | output | 1 | Maskable interrupt |
| nmi | output | 1 | Non-maskable interrupt |

## Verification
The bench drives the error pulses in the following patterns:
- An isolated pulse of each kind, which separates recording from not recording.
- A repeated pulse while the flag is still set, which shows whether the sticky flag blocks a new error and its address.
- A pulse with the address latch off, which shows the flag being set without the address being stored.
- A pulse while the code enable bit is off, which shows it being dropped.
- A pulse in the same cycle as a clear, which separates set priority from clear priority.

The key register is written in the following sequences:
- The correct pair.
- A wrong second byte.
- A repeated first byte.
- A pair followed by a stray first byte.
- A pair spent on a control write.

These show exactly which histories allow the enable bit to be cleared. The interrupt enables are swept with the NMI select both off and on, which shows the override on double errors.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int WR_W = 8;

  typedef enum logic [2:0] {
    IDX_CTRL  = 3'd0,
    IDX_IEN   = 3'd1,
    IDX_STAT  = 3'd2,
    IDX_CLR   = 3'd3,
    IDX_SADDR = 3'd4,
    IDX_DADDR = 3'd5,
    IDX_KEY   = 3'd6,
    IDX_SPARE = 3'd7
  } reg_idx_e;

  localparam logic [WR_W-1:0] KEY_FIRST  = 8'hAE;
  localparam logic [WR_W-1:0] KEY_SECOND = 8'h75;

  localparam int ERR_KINDS  = 2;
  localparam int ERR_SINGLE = 0;
  localparam int ERR_DOUBLE = 1;

  localparam int CTRL_ENA   = 0;
  localparam int CTRL_LATCH = 1;
  localparam int IEN_SINGLE = 0;
  localparam int IEN_DOUBLE = 1;
  localparam int IEN_NMISEL = 2;
endpackage

// File: rtl/ecc_key_guard.sv
module ecc_key_guard
  import ecc_err_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            key_we,
  input  logic [WR_W-1:0] key_val,
  input  logic            ctrl_we,
  output logic            unlocked
);
  typedef enum logic [1:0] {KG_LOCKED, KG_HALF, KG_OPEN} kg_state_e;
  kg_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KG_LOCKED;
    end else if (key_we) begin
      if (key_val == KEY_FIRST)
        state_q <= KG_HALF;
      else if (state_q == KG_HALF && key_val == KEY_SECOND)
        state_q <= KG_OPEN;
      else
        state_q <= KG_LOCKED;
    end else if (ctrl_we) begin
      state_q <= KG_LOCKED;
    end
  end

  assign unlocked = (state_q == KG_OPEN);
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              latch_en,
  input  logic              err_pulse,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              clr,
  output logic              flag,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      addr <= '0;
    end else if (flag) begin
      if (clr) flag <= 1'b0;
    end else if (err_pulse && enable) begin
      flag <= 1'b1;
      if (latch_en) addr <= err_addr;
    end
  end
endmodule

// File: rtl/ecc_irq_gen.sv
module ecc_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic s_flag,
  input  logic d_flag,
  input  logic s_ie,
  input  logic d_ie,
  input  logic nmi_sel,
  output logic irq,
  output logic nmi
);
  logic irq_d, nmi_d;

  always_comb begin
    nmi_d = d_flag & nmi_sel;
    irq_d = (s_flag & s_ie) | (d_flag & d_ie & ~nmi_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      nmi <= 1'b0;
    end else begin
      irq <= irq_d;
      nmi <= nmi_d;
    end
  end
endmodule

// File: rtl/ecc_err_ctrl.sv
module ecc_err_ctrl
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ecc_en_cfg,
  input  logic [2:0]        reg_sel,
  input  logic              reg_we,
  input  logic [WR_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sec_pulse,
  input  logic [ADDR_W-1:0] sec_addr,
  input  logic              ded_pulse,
  input  logic [ADDR_W-1:0] ded_addr,
  output logic              irq,
  output logic              nmi
);
  logic ecc_en_q, ale_q, sie_q, die_q, nmisel_q;
  logic ctrl_we, ien_we, clr_we, key_we, unlocked;
  logic [ERR_KINDS-1:0] pulse_v, flag_v, clr_v;
  logic [ADDR_W-1:0]    in_addr [ERR_KINDS];
  logic [ADDR_W-1:0]    cap_addr [ERR_KINDS];
  logic [DATA_W-1:0]    rd_next;

  assign ctrl_we = reg_we && (reg_sel == IDX_CTRL);
  assign ien_we  = reg_we && (reg_sel == IDX_IEN);
  assign clr_we  = reg_we && (reg_sel == IDX_CLR);
  assign key_we  = reg_we && (reg_sel == IDX_KEY);

  assign pulse_v[ERR_SINGLE] = sec_pulse;
  assign pulse_v[ERR_DOUBLE] = ded_pulse;
  assign in_addr[ERR_SINGLE] = sec_addr;
  assign in_addr[ERR_DOUBLE] = ded_addr;
  assign clr_v = clr_we ? reg_wdata[ERR_KINDS-1:0] : '0;

  ecc_key_guard u_key (
    .clk(clk), .rst(rst), .key_we(key_we), .key_val(reg_wdata),
    .ctrl_we(ctrl_we), .unlocked(unlocked)
  );

  for (genvar k = 0; k < ERR_KINDS; k++) begin : g_cap
    ecc_err_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk(clk), .rst(rst), .enable(ecc_en_q), .latch_en(ale_q),
      .err_pulse(pulse_v[k]), .err_addr(in_addr[k]), .clr(clr_v[k]),
      .flag(flag_v[k]), .addr(cap_addr[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ecc_en_q <= ecc_en_cfg;
      ale_q    <= 1'b0;
      sie_q    <= 1'b0;
      die_q    <= 1'b0;
      nmisel_q <= 1'b0;
    end else begin
      if (ctrl_we) begin
        ale_q <= reg_wdata[CTRL_LATCH];
        if (reg_wdata[CTRL_ENA])
          ecc_en_q <= 1'b1;
        else if (unlocked)
          ecc_en_q <= 1'b0;
      end
      if (ien_we) begin
        sie_q    <= reg_wdata[IEN_SINGLE];
        die_q    <= reg_wdata[IEN_DOUBLE];
        nmisel_q <= nmisel_q | reg_wdata[IEN_NMISEL];
      end
    end
  end

  ecc_irq_gen u_irq (
    .clk(clk), .rst(rst), .s_flag(flag_v[ERR_SINGLE]), .d_flag(flag_v[ERR_DOUBLE]),
    .s_ie(sie_q), .d_ie(die_q), .nmi_sel(nmisel_q), .irq(irq), .nmi(nmi)
  );

  always_comb begin
    rd_next = '0;
    case (reg_sel)
      IDX_CTRL: begin
        rd_next[CTRL_ENA]   = ecc_en_q;
        rd_next[CTRL_LATCH] = ale_q;
      end
      IDX_IEN: begin
        rd_next[IEN_SINGLE] = sie_q;
        rd_next[IEN_DOUBLE] = die_q;
        rd_next[IEN_NMISEL] = nmisel_q;
      end
      IDX_STAT, IDX_CLR: rd_next[ERR_KINDS-1:0] = flag_v;
      IDX_SADDR: rd_next = DATA_W'(cap_addr[ERR_SINGLE]);
      IDX_DADDR: rd_next = DATA_W'(cap_addr[ERR_DOUBLE]);
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/ecc_err_ctrl_chk.sv
module ecc_err_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ecc_en,
  input logic              ale,
  input logic              sie,
  input logic              die,
  input logic              nmisel,
  input logic              unlocked,
  input logic              s_flag,
  input logic              d_flag,
  input logic [ADDR_W-1:0] s_addr,
  input logic [ADDR_W-1:0] d_addr,
  input logic              irq,
  input logic              nmi
);
  AST_SFLAG_HOLDS_ADDR: assert property (@(posedge clk) disable iff (rst)
    s_flag |=> $stable(s_addr)); // R3
  AST_DFLAG_HOLDS_ADDR: assert property (@(posedge clk) disable iff (rst)
    d_flag |=> $stable(d_addr)); // R3
  AST_NO_LATCH_WITHOUT_ALE: assert property (@(posedge clk) disable iff (rst)
    !ale |=> ($stable(s_addr) && $stable(d_addr))); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((s_flag && sie) || (d_flag && die && !nmisel))); // R6
  AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (rst)
    nmi |-> $past(d_flag && nmisel)); // R7
  AST_NMISEL_STICKY: assert property (@(posedge clk) disable iff (rst)
    nmisel |=> nmisel); // R7
  AST_ENA_CLEAR_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    $fell(ecc_en) |-> $past(unlocked)); // R8
  AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!ecc_en && !s_flag && !d_flag) |=> (!s_flag && !d_flag)); // R10
endmodule

bind ecc_err_ctrl ecc_err_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ecc_en(ecc_en_q), .ale(ale_q), .sie(sie_q), .die(die_q),
  .nmisel(nmisel_q), .unlocked(unlocked), .s_flag(flag_v[0]), .d_flag(flag_v[1]),
  .s_addr(cap_addr[0]), .d_addr(cap_addr[1]), .irq(irq), .nmi(nmi)
);

// File: tb/sim_ecc_err_ctrl.sv
module sim_ecc_err_ctrl;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ecc_en_cfg = 1'b1;
  logic [2:0] reg_sel = 3'd0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [DW-1:0] reg_rdata;
  logic sec_pulse = 1'b0, ded_pulse = 1'b0;
  logic [AW-1:0] sec_addr = '0, ded_addr = '0;
  logic irq, nmi;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecc_err_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .ecc_en_cfg(ecc_en_cfg), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_pulse(sec_pulse), .sec_addr(sec_addr),
    .ded_pulse(ded_pulse), .ded_addr(ded_addr), .irq(irq), .nmi(nmi)
  );

  // behavioural reference
  bit m_en, m_ale, m_sie, m_die, m_nsel, m_sf, m_df, m_irq, m_nmi;
  logic [AW-1:0] m_sa, m_da;
  logic [DW-1:0] m_rd;
  int m_key;

  function automatic logic [DW-1:0] m_read(input int idx);
    case (idx)
      0: return DW'({m_ale, m_en});
      1: return DW'({m_nsel, m_die, m_sie});
      2, 3: return DW'({m_df, m_sf});
      4: return DW'(m_sa);
      5: return DW'(m_da);
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = ecc_en_cfg; m_ale = 0; m_sie = 0; m_die = 0; m_nsel = 0;
      m_sf = 0; m_df = 0; m_sa = '0; m_da = '0; m_key = 0;
      m_rd = '0; m_irq = 0; m_nmi = 0;
    end else begin
      bit cs, cd;
      m_rd  = m_read(int'(reg_sel));
      m_irq = (m_sf && m_sie) || (m_df && m_die && !m_nsel);
      m_nmi = m_df && m_nsel;
      cs = reg_we && reg_sel == 3 && reg_wdata[0];
      cd = reg_we && reg_sel == 3 && reg_wdata[1];
      if (m_sf) begin if (cs) m_sf = 0; end
      else if (sec_pulse && m_en) begin m_sf = 1; if (m_ale) m_sa = sec_addr; end
      if (m_df) begin if (cd) m_df = 0; end
      else if (ded_pulse && m_en) begin m_df = 1; if (m_ale) m_da = ded_addr; end
      if (reg_we && reg_sel == 0) begin
        if (reg_wdata[0]) m_en = 1; else if (m_key == 2) m_en = 0;
        m_ale = reg_wdata[1];
        m_key = 0;
      end
      if (reg_we && reg_sel == 6) begin
        if (reg_wdata == 8'hAE) m_key = 1;
        else if (m_key == 1 && reg_wdata == 8'h75) m_key = 2;
        else m_key = 0;
      end
      if (reg_we && reg_sel == 1) begin
        m_sie = reg_wdata[0]; m_die = reg_wdata[1];
        if (reg_wdata[2]) m_nsel = 1;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(cur_req, "rdata", reg_rdata, m_rd);
      check(cur_req, "irq", DW'(irq), DW'(m_irq));
      check(cur_req, "nmi", DW'(nmi), DW'(m_nmi));
    end
  end

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk); reg_sel = 3'(idx); reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int idx, output logic [DW-1:0] v);
    @(negedge clk); reg_sel = 3'(idx); reg_we = 0;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic err(input bit dbl, input logic [AW-1:0] a);
    @(negedge clk);
    if (dbl) begin ded_pulse = 1; ded_addr = a; end
    else begin sec_pulse = 1; sec_addr = a; end
    @(negedge clk); sec_pulse = 0; ded_pulse = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); cmp_on = 1; rst = 0;
    // R1 reset state
    cur_req = "R1";
    rd(0, v); check("R1", "ctrl after reset", v, 32'h1);
    rd(2, v); check("R1", "status after reset", v, 32'h0);
    check("R1", "irq after reset", DW'(irq), 32'h0);
    // R8 clear without key
    cur_req = "R8";
    wr(0, 8'h00); rd(0, v); check("R8", "enable kept without key", v, 32'h1);
    wr(6, 8'hAE); wr(6, 8'h75); wr(0, 8'h02);
    rd(0, v); check("R8", "enable cleared after key", v, 32'h2);
    // R10 errors ignored when disabled
    cur_req = "R10";
    err(0, 32'h55); err(1, 32'h66);
    rd(2, v); check("R10", "status while disabled", v, 32'h0);
    wr(0, 8'h03); rd(0, v); check("R8", "enable set freely", v, 32'h3);
    // R2 / R4 capture
    cur_req = "R2";
    err(0, 32'h100); rd(2, v); check("R2", "single flag", v, 32'h1);
    rd(4, v); check("R4", "single addr latched", v, 32'h100);
    cur_req = "R3";
    err(0, 32'h200); rd(4, v); check("R3", "single addr held", v, 32'h100);
    err(1, 32'h300); rd(2, v); check("R2", "both flags", v, 32'h3);
    rd(5, v); check("R4", "double addr latched", v, 32'h300);
    err(1, 32'h301); rd(5, v); check("R3", "double addr held", v, 32'h300);
    // R5 clear
    cur_req = "R5";
    rd(3, v); check("R5", "clear reg reads flags", v, 32'h3);
    wr(3, 8'h01); rd(2, v); check("R5", "single cleared", v, 32'h2);
    wr(3, 8'h02); rd(2, v); check("R5", "double cleared", v, 32'h0);
    // R4 no latch
    cur_req = "R4";
    wr(0, 8'h01); err(0, 32'h400);
    rd(2, v); check("R4", "flag set without latch", v, 32'h1);
    rd(4, v); check("R4", "addr not latched", v, 32'h100);
    // R5 clear meets new pulse while set
    cur_req = "R5";
    @(negedge clk); reg_sel = 3; reg_we = 1; reg_wdata = 8'h01; sec_pulse = 1; sec_addr = 32'h777;
    @(negedge clk); reg_we = 0; sec_pulse = 0;
    rd(2, v); check("R5", "clear wins over pulse on set flag", v, 32'h0);
    // R6 interrupts
    cur_req = "R6";
    wr(1, 8'h01); err(0, 32'h10); idle(1);
    check("R6", "single irq", DW'(irq), 32'h1);
    wr(3, 8'h01); idle(1); check("R6", "irq drops after clear", DW'(irq), 32'h0);
    wr(1, 8'h02); err(1, 32'h20); idle(1);
    check("R6", "double irq", DW'(irq), 32'h1);
    check("R7", "no nmi without select", DW'(nmi), 32'h0);
    // R7 NMI override and sticky select
    cur_req = "R7";
    wr(1, 8'h06); idle(1);
    check("R7", "nmi raised", DW'(nmi), 32'h1);
    check("R7", "irq suppressed by nmi select", DW'(irq), 32'h0);
    wr(1, 8'h02); idle(1);
    rd(1, v); check("R7", "select not cleared by write 0", v, 32'h6);
    check("R7", "irq still suppressed", DW'(irq), 32'h0);
    wr(3, 8'h02); idle(1); check("R7", "nmi drops after clear", DW'(nmi), 32'h0);
    // R9 key sequences
    cur_req = "R9";
    wr(6, 8'hAE); wr(6, 8'h11); wr(0, 8'h00);
    rd(0, v); check("R9", "wrong key relocks", v, 32'h1);
    wr(6, 8'hAE); wr(6, 8'hAE); wr(6, 8'h75); wr(0, 8'h01);
    wr(0, 8'h00); rd(0, v); check("R9", "unlock used by first ctrl write", v, 32'h1);
    wr(6, 8'h75); wr(0, 8'h00); rd(0, v); check("R9", "second key alone", v, 32'h1);
    wr(6, 8'hAE); wr(6, 8'h75); wr(6, 8'hAE); wr(0, 8'h00);
    rd(0, v); check("R9", "stray first key relocks", v, 32'h1);
    wr(6, 8'hAE); wr(6, 8'h75); wr(0, 8'h00);
    rd(0, v); check("R9", "repeat pair opens after relock", v, 32'h0);
    // R11 read map
    cur_req = "R11";
    rd(6, v); check("R11", "key reads zero", v, 32'h0);
    rd(7, v); check("R11", "spare reads zero", v, 32'h0);
    idle(2);
    finish_run();
  end
endmodule